// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

A single DMA channel that moves bytes out of memory and delivers them to a peripheral as a valid/ready byte stream. Software programs the channel through a small register bus. The channel has two descriptor slots. Each slot holds a byte count and a start address. While one slot is being transferred, software can load the other slot, so the stream continues with no gap between buffers.

A four-state status machine tracks how many buffers are waiting: idle, stall (enabled but empty), on (one buffer) and next (two buffers). Writing a slot's start address hands that slot to the channel, so software writes the count first and the address second. Slots are consumed strictly in turn, starting with slot 0 after enable. Three interrupt causes are available: stall (the channel ran dry), next-free (a slot can be refilled) and error (memory returned an error response). Each cause has its own enable bit, and all of them are combined onto one interrupt line.

On the memory side, each byte is fetched with one request/acknowledge exchange. To shut the channel down, software masks the buffer interrupts and lets the pending buffers drain, then clears the enable bit, and the channel returns to idle.

Top module: `pdma_channel`

## Requirements
- R1: After reset the state is idle (status bits [5:4] = 0), `irq`, `mem_req` and `tx_valid` are low, and `port_sel` is 0.
- R2: Setting control bit 4 while idle moves the state to stall (status = 0x10). The slot that is loaded next and the slot that is transferred next both restart at slot 0.
- R3: Writing the start address of the expected slot (slot 0 at 0x24, slot 1 at 0x34) while the channel is in stall or on raises the pending count by one (stall→on, on→next). Slots are taken strictly in turn. Other start-address writes are ignored, and so is any such write while the channel is idle, in next, or disabled.
- R4: The count registers (slot 0 at 0x20, slot 1 at 0x30) and the address registers read back what was written. A count write to a slot that holds a pending buffer is ignored.
- R5: For each buffer, the channel reads the bytes from address base up to base+count−1, in order, and emits each one on `tx_data` with `tx_valid` held until `tx_ready` is high. A count of 0 completes the buffer with no memory traffic.
- R6: When a buffer completes, the state moves from next to on, or from on to stall.
- R7: If a buffer completes in the same cycle as an accepted start-address write, the state stays on, and the newly loaded slot becomes the active one.
- R8: Register 0x14 reads count minus bytes fetched for the active buffer, and reads 0 when no buffer is pending.
- R9: Interrupt register 0x04 has three flags. Bit 0 (stall) is high exactly when the state is stall. Bit 1 (next-free) is high exactly when the state is on. Bit 3 (error) is sticky, and writing 1 to bit 3 clears it.
- R10: `irq` is registered one cycle after the OR of the three flag/enable pairs: control bit 0 with the stall flag, control bit 1 with the next-free flag, and control bit 3 with the error flag.
- R11: An error response on an acknowledged memory read sets the error flag, emits no byte for that read, abandons the rest of that buffer and completes it as in R6.
- R12: Clearing control bit 4 moves the state from stall to idle in one cycle. From on or next, the pending buffers drain first and the channel then goes to idle without passing through stall.
- R13: Register 0x08 holds the peripheral select, which drives `port_sel` and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (read data follows one cycle later) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's `reg_addr` |
| irq | output | 1 | Combined interrupt request |
| port_sel | output | PORT_W | Selected peripheral |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_ack | input | 1 | Memory acknowledge, data valid |
| mem_err | input | 1 | Error response, sampled together with `mem_ack` |
| mem_rdata | input | 8 | Memory read byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_ready | input | 1 | Peripheral accepts the byte |

## Verification
The case that needs care is a buffer completing in the same cycle that software arms the other slot. The pending count then rises and falls at once, and the active slot switches to the slot that was just armed. The bench provokes this with a zero-length buffer in slot 0 whose completion lands on the cycle that a back-to-back write arms slot 1. It then checks three things: the status reads on rather than next or stall, the remaining count belongs to the slot-1 buffer, and the scoreboard receives exactly the slot-1 bytes.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STALL = 2'd1,
    ST_ON    = 2'd2,
    ST_NEXT  = 2'd3
  } chan_state_e;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_INTR   = 8'h04;
  localparam logic [7:0] OFF_PORT   = 8'h08;
  localparam logic [7:0] OFF_STAT   = 8'h0C;
  localparam logic [7:0] OFF_REMAIN = 8'h14;
  localparam logic [7:0] OFF_CNT0   = 8'h20;
  localparam logic [7:0] OFF_BASE0  = 8'h24;
  localparam logic [7:0] OFF_SLOT_STRIDE = 8'h10;

  localparam int BIT_STALL = 0;
  localparam int BIT_NFB   = 1;
  localparam int BIT_ERR   = 3;
  localparam int BIT_EN    = 4;
endpackage

// File: rtl/pdma_state.sv
module pdma_state
  import pdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [1:0]  base_hit,
  input  logic        done,
  output chan_state_e state,
  output logic        load_slot,
  output logic        act_slot,
  output logic        arm_ok
);
  // a base write is accepted only for the slot whose turn it is
  assign arm_ok = base_hit[load_slot] && en &&
                  (state == ST_STALL || state == ST_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      load_slot <= 1'b0;
      act_slot  <= 1'b0;
    end else begin
      if (arm_ok) load_slot <= ~load_slot;
      if (done)   act_slot  <= ~act_slot;
      unique case (state)
        ST_IDLE: if (en) begin
          state     <= ST_STALL;
          load_slot <= 1'b0;
          act_slot  <= 1'b0;
        end
        ST_STALL: begin
          if (!en)         state <= ST_IDLE;
          else if (arm_ok) state <= ST_ON;
        end
        ST_ON: begin
          if (arm_ok && !done)      state <= ST_NEXT;
          else if (done && !arm_ok) state <= en ? ST_STALL : ST_IDLE;
        end
        ST_NEXT: if (done) state <= ST_ON;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pdma_mover.sv
module pdma_mover #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic [CNT_W-1:0]  cnt_act,
  input  logic [ADDR_W-1:0] base_act,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [7:0]        mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              done,
  output logic              err_set,
  output logic [CNT_W-1:0]  remain
);
  typedef enum logic [1:0] {MV_IDLE, MV_REQ, MV_SEND} mv_e;
  mv_e              mst;
  logic [CNT_W-1:0] offs;

  assign err_set  = (mst == MV_REQ) && mem_ack && mem_err;
  assign done     = ((mst == MV_IDLE) && busy && (offs == cnt_act)) || err_set;
  assign mem_req  = (mst == MV_REQ);
  assign tx_valid = (mst == MV_SEND);
  assign mem_addr = base_act + ADDR_W'(offs);
  assign remain   = busy ? (cnt_act - offs) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mst     <= MV_IDLE;
      offs    <= '0;
      tx_data <= '0;
    end else begin
      unique case (mst)
        MV_IDLE: if (busy) begin
          if (offs == cnt_act) offs <= '0;
          else                 mst  <= MV_REQ;
        end
        MV_REQ: if (mem_ack) begin
          if (mem_err) begin
            offs <= '0;
            mst  <= MV_IDLE;
          end else begin
            tx_data <= mem_rdata;
            offs    <= offs + 1'b1;
            mst     <= MV_SEND;
          end
        end
        MV_SEND: if (tx_ready) mst <= MV_IDLE;
        default: mst <= MV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int PORT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic [7:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  chan_state_e            state,
  input  logic                   act_slot,
  input  logic                   load_slot,
  input  logic                   arm_ok,
  input  logic                   err_set,
  input  logic [CNT_W-1:0]       remain,
  output logic [4:0]             ctrl_q,
  output logic [PORT_W-1:0]      port_q,
  output logic [1:0][CNT_W-1:0]  slot_cnt,
  output logic [1:0][ADDR_W-1:0] slot_base,
  output logic [1:0]             base_hit,
  output logic                   irq_q
);
  logic err_q, stall_f, nfb_f;
  logic [31:0] rd_val;

  assign stall_f = (state == ST_STALL);
  assign nfb_f   = (state == ST_ON);

  for (genvar s = 0; s < 2; s++) begin : g_slot
    localparam logic [7:0] CNT_OFF  = OFF_CNT0 + 8'(s) * OFF_SLOT_STRIDE;
    localparam logic [7:0] BASE_OFF = OFF_BASE0 + 8'(s) * OFF_SLOT_STRIDE;
    logic              loaded;
    logic [CNT_W-1:0]  cnt_r;
    logic [ADDR_W-1:0] base_r;

    assign loaded       = (state == ST_NEXT) || (state == ST_ON && act_slot == 1'(s));
    assign base_hit[s]  = reg_we && (reg_addr == BASE_OFF);
    assign slot_cnt[s]  = cnt_r;
    assign slot_base[s] = base_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_r  <= '0;
        base_r <= '0;
      end else begin
        if (reg_we && reg_addr == CNT_OFF && !loaded) cnt_r <= reg_wdata[CNT_W-1:0];
        if (arm_ok && load_slot == 1'(s))             base_r <= reg_wdata[ADDR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      port_q <= '0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (reg_we && reg_addr == OFF_CTRL) ctrl_q <= reg_wdata[4:0] & 5'b11011;
      if (reg_we && reg_addr == OFF_PORT) port_q <= reg_wdata[PORT_W-1:0];
      if (err_set) err_q <= 1'b1;
      else if (reg_we && reg_addr == OFF_INTR && reg_wdata[BIT_ERR]) err_q <= 1'b0;
      irq_q <= (ctrl_q[BIT_STALL] & stall_f) | (ctrl_q[BIT_NFB] & nfb_f) |
               (ctrl_q[BIT_ERR] & err_q);
    end
  end

  always_comb begin
    rd_val = '0;
    case (reg_addr)
      OFF_CTRL:   rd_val = 32'(ctrl_q);
      OFF_INTR:   rd_val = {28'd0, err_q, 1'b0, nfb_f, stall_f};
      OFF_PORT:   rd_val = 32'(port_q);
      OFF_STAT:   rd_val = {26'd0, state, 4'd0};
      OFF_REMAIN: rd_val = 32'(remain);
      OFF_CNT0:   rd_val = 32'(slot_cnt[0]);
      OFF_BASE0:  rd_val = 32'(slot_base[0]);
      OFF_CNT0 + OFF_SLOT_STRIDE:  rd_val = 32'(slot_cnt[1]);
      OFF_BASE0 + OFF_SLOT_STRIDE: rd_val = 32'(slot_base[1]);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_val;
  end
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic [PORT_W-1:0] port_sel,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [7:0]        mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready
);
  chan_state_e            state;
  logic                   load_slot, act_slot, arm_ok, done, err_set, busy;
  logic [4:0]             ctrl_q;
  logic [1:0]             base_hit;
  logic [1:0][CNT_W-1:0]  slot_cnt;
  logic [1:0][ADDR_W-1:0] slot_base;
  logic [CNT_W-1:0]       remain;

  assign busy = (state == ST_ON) || (state == ST_NEXT);

  pdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PORT_W(PORT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .state(state),
    .act_slot(act_slot), .load_slot(load_slot), .arm_ok(arm_ok),
    .err_set(err_set), .remain(remain), .ctrl_q(ctrl_q), .port_q(port_sel),
    .slot_cnt(slot_cnt), .slot_base(slot_base), .base_hit(base_hit),
    .irq_q(irq)
  );

  pdma_state u_state (
    .clk(clk), .rst(rst), .en(ctrl_q[BIT_EN]), .base_hit(base_hit),
    .done(done), .state(state), .load_slot(load_slot),
    .act_slot(act_slot), .arm_ok(arm_ok)
  );

  pdma_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mover (
    .clk(clk), .rst(rst), .busy(busy),
    .cnt_act(slot_cnt[act_slot]), .base_act(slot_base[act_slot]),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .done(done),
    .err_set(err_set), .remain(remain)
  );
endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        state,
  input logic [4:0]        ctrl_q,
  input logic              done,
  input logic              arm_ok,
  input logic              irq,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data
);
  import pdma_pkg::*;

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !ctrl_q[BIT_EN]) |=> state == ST_IDLE);

  // R6
  no_skip_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_STALL |=> state != ST_NEXT);

  // R7
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ON && done && arm_ok) |=> state == ST_ON);

  // R3
  next_block_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_NEXT |-> !arm_ok);

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R10
  stall_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STALL && ctrl_q[BIT_STALL]) |=> irq);
endmodule

bind pdma_channel pdma_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .state(state), .ctrl_q(ctrl_q), .done(done),
  .arm_ok(arm_ok), .irq(irq), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data)
);

// File: tb/tb_pdma_channel.sv
`timescale 1ns/1ps
module tb_pdma_channel;
  localparam logic [7:0] A_CTRL = 8'h00, A_INTR = 8'h04, A_PORT = 8'h08,
                         A_STAT = 8'h0C, A_REM = 8'h14, A_CNT0 = 8'h20,
                         A_BASE0 = 8'h24, A_CNT1 = 8'h30, A_BASE1 = 8'h34;

  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, mem_req, mem_ack = 1'b0, mem_err = 1'b0, tx_valid, tx_ready = 1'b0;
  logic [3:0]  port_sel;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rdata = '0, tx_data;
  logic        ready_en = 1'b0;
  logic [1:0]  rcnt = '0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [7:0]  exp_q[$];
  int          nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  pdma_channel dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .port_sel(port_sel), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  // memory model: one-cycle acknowledge, error on a chosen address
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0; mem_err = 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack = 1'b1; mem_rdata = mbyte(mem_addr); mem_err = (mem_addr == err_addr);
    end else begin
      mem_ack = 1'b0; mem_err = 1'b0;
    end
  end

  // ready pattern and scoreboard monitor (R5)
  always @(negedge clk) begin
    rcnt = rcnt + 2'd1;
    tx_ready = ready_en && (rcnt != 2'b01);
    if (!rst && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte", 32'(tx_data), 32'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(tx_data == e, "R5 stream byte", 32'(tx_data), 32'(e));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wr2(input logic [7:0] a0, input logic [31:0] d0,
                     input logic [7:0] a1, input logic [31:0] d1);
    @(negedge clk); reg_we = 1'b1; reg_addr = a0; reg_wdata = d0;
    @(negedge clk); reg_addr = a1; reg_wdata = d1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic push_buf(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(mbyte(base + 32'(i)));
  endtask

  task automatic wait_state(input logic [1:0] s, input string req);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 1000; i++) begin
      rd(A_STAT, v);
      if (v[5:4] == s) break;
    end
    chk(v[5:4] == s, req, 32'(v[5:4]), 32'(s));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!irq && !mem_req && !tx_valid, "R1 outputs idle", {irq, mem_req, tx_valid}, 0);
    chk(port_sel == 0, "R1 port_sel", 32'(port_sel), 0);
    rd(A_STAT, v); chk(v == 32'h0, "R1 status idle", v, 32'h0);

    // R13 port select
    wr(A_PORT, 32'h5);
    chk(port_sel == 4'h5, "R13 port_sel", 32'(port_sel), 32'h5);
    rd(A_PORT, v); chk(v == 32'h5, "R13 readback", v, 32'h5);

    // R2 enable with interrupts masked; R10 gating
    wr(A_CTRL, 32'h10);
    rd(A_STAT, v); chk(v == 32'h10, "R2 stall after enable", v, 32'h10);
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R10 masked stall", 32'(irq), 0);
    wr(A_CTRL, 32'h1B);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R10 stall irq", 32'(irq), 1);
    rd(A_INTR, v); chk(v == 32'h1, "R9 stall flag", v, 32'h1);

    // R3/R4/R8 fill both slots with the stream held
    push_buf(32'h100, 4);
    wr(A_CNT0, 4); wr(A_BASE0, 32'h100);
    rd(A_STAT, v); chk(v == 32'h20, "R3 stall->on", v, 32'h20);
    push_buf(32'h240, 6);
    wr(A_CNT1, 6); wr(A_BASE1, 32'h240);
    rd(A_STAT, v); chk(v == 32'h30, "R3 on->next", v, 32'h30);
    wr(A_CNT0, 9);
    rd(A_CNT0, v); chk(v == 32'h4, "R4 loaded count kept", v, 32'h4);
    wr(A_BASE0, 32'h999);
    rd(A_BASE0, v); chk(v == 32'h100, "R3 arm in next ignored", v, 32'h100);
    rd(A_REM, v); chk(v == 32'h3, "R8 remaining", v, 32'h3);
    chk(irq == 1'b0, "R10 no flag in next", 32'(irq), 0);

    ready_en = 1'b1;
    wait_state(2'd2, "R6 next->on");
    rd(A_INTR, v); chk(v == 32'h2, "R9 next-free flag", v, 32'h2);
    chk(irq == 1'b1, "R10 next-free irq", 32'(irq), 1);
    wait_state(2'd1, "R6 on->stall");
    chk(exp_q.size() == 0, "R5 all bytes out", exp_q.size(), 0);

    // R3 strict alternation: slot 1 write while slot 0 expected
    wr(A_CNT1, 2); wr(A_BASE1, 32'h300);
    rd(A_STAT, v); chk(v == 32'h10, "R3 wrong slot ignored", v, 32'h10);
    rd(A_BASE1, v); chk(v == 32'h240, "R3 wrong slot base kept", v, 32'h240);

    // R11 error mid-buffer
    err_addr = 32'h402;
    push_buf(32'h400, 2);
    wr(A_CNT0, 5); wr(A_BASE0, 32'h400);
    push_buf(32'h500, 2);
    wr(A_CNT1, 2); wr(A_BASE1, 32'h500);
    wait_state(2'd1, "R11 completes to stall");
    chk(exp_q.size() == 0, "R11 rest abandoned", exp_q.size(), 0);
    rd(A_INTR, v); chk(v == 32'h9, "R11 error flag", v, 32'h9);
    wr(A_INTR, 32'h8);
    rd(A_INTR, v); chk(v == 32'h1, "R9 error cleared", v, 32'h1);
    err_addr = 32'hFFFF_FFFF;

    // R7 zero-length buffer completes as slot 1 is armed
    ready_en = 1'b0;
    repeat (4) @(negedge clk);
    wr(A_CNT0, 0); wr(A_CNT1, 3);
    push_buf(32'h600, 3);
    wr2(A_BASE0, 32'h0, A_BASE1, 32'h600);
    repeat (4) @(negedge clk);
    rd(A_STAT, v); chk(v == 32'h20, "R7 stays on", v, 32'h20);
    rd(A_REM, v); chk(v == 32'h2, "R7 slot1 active", v, 32'h2);

    // R12 disable while draining
    wr(A_CTRL, 32'h03);
    rd(A_STAT, v); chk(v == 32'h20, "R12 drains first", v, 32'h20);
    ready_en = 1'b1;
    wait_state(2'd0, "R12 idle after drain");
    chk(exp_q.size() == 0, "R5 zero-length buffer", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R12 no stall on disable", 32'(irq), 0);
    wr(A_CNT0, 1); wr(A_BASE0, 32'h700);
    rd(A_STAT, v); chk(v == 32'h0, "R3 arm while idle ignored", v, 32'h0);
    rd(A_BASE0, v); chk(v == 32'h0, "R3 idle base kept", v, 32'h0);

    // R2 re-enable restarts at slot 0
    wr(A_CTRL, 32'h10);
    wr(A_BASE1, 32'h900);
    rd(A_STAT, v); chk(v == 32'h10, "R2 slot1 not first", v, 32'h10);
    push_buf(32'h800, 2);
    wr(A_CNT0, 2); wr(A_BASE0, 32'h800);
    rd(A_STAT, v); chk(v[5:4] != 2'd1, "R2 slot0 first", v, 32'h20);
    wait_state(2'd1, "R6 back to stall");
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R5 final drain", exp_q.size(), 0);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, v); chk(v == 32'h0, "R12 stall->idle", v, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule